// File: doc/BRIEF.md
# Receive Pair Polarity Detector and Corrector

This block sits in front of the receive decoder of a twisted-pair port. It watches two comparator levels, one raised by a positive excursion on the pair and one by a negative excursion. It times how long each first excursion lasts, and it accepts the excursion as a link pulse only when that width falls inside a programmable window of clock cycles. A pulse takes its polarity from its leading excursion. An opposite excursion that follows right behind, within a short tail window, belongs to the same pulse.

While the link monitor reports link fail, the block counts consecutive qualified pulses of one polarity and raises a run-complete flag once enough of them have been seen. The link monitor uses that flag to declare link pass. On that rising edge the block latches the run's polarity into an invert control. From then on it passes on as valid link pulses only those whose raw polarity agrees with the latched polarity. During link pass, a frame end delimiter that is reported as reversed flips the invert control. Falling back to link fail re-arms the run counter. The corrected receive bit is the raw bit exclusive-ORed with the invert control and has no register stage.

Top module: `rx_polarity_fixer`

## Requirements
- R1: A leading excursion qualifies as a link pulse only when its level is sampled high on at least MIN_CYC and at most MAX_CYC consecutive clock edges.
- R2: A pulse whose leading excursion is positive counts once as positive, and one whose leading excursion is negative counts once as negative. An opposite excursion that begins within TAIL_CYC cycles of the leading one ending is absorbed and not counted.
- R3: During link fail (link_up low), qualified pulses of either polarity raise lp_valid for one cycle.
- R4: run_done rises after RUN_LEN consecutive qualified pulses of the same polarity during link fail. A qualified pulse of the other polarity restarts the run at one.
- R5: On the rising edge of link_up with run_done high, invert becomes 1 if the run was negative and 0 if the run was positive.
- R6: During link pass, lp_valid is raised only for qualified pulses whose raw polarity is negative when invert is 1, or positive when invert is 0.
- R7: During link pass, etd_valid together with etd_rev toggles invert. etd_valid without etd_rev leaves invert unchanged, and during link fail delimiter reports have no effect.
- R8: rx_fixed equals rx_raw XOR invert in the same cycle.
- R9: Each fall of link_up clears the run, so run_done goes low, and a later run sets invert afresh on the next link pass.
- R10: A leading excursion that is too short or too long neither adds to a run nor breaks one.
- R11: After reset invert, run_done and lp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_lvl | input | 1 | Positive-excursion comparator level |
| neg_lvl | input | 1 | Negative-excursion comparator level |
| link_up | input | 1 | Link monitor state: 1 = link pass, 0 = link fail |
| etd_valid | input | 1 | One-cycle strobe: a valid frame end delimiter was seen |
| etd_rev | input | 1 | With etd_valid: the delimiter appeared with reversed polarity |
| rx_raw | input | 1 | Raw receive data bit |
| rx_fixed | output | 1 | Polarity-corrected receive data bit |
| invert | output | 1 | Current invert control |
| lp_valid | output | 1 | One-cycle strobe for an accepted link pulse |
| run_done | output | 1 | Enough identical consecutive pulses seen in link fail |

## Verification
The bench sweeps the leading-excursion width across the window and on both sides of it. A design that is off by one at either bound would accept or drop a pulse at exactly MIN_CYC or MAX_CYC. Bipolar pulses in both orders catch a design that counts the trailing excursion as a second pulse or classifies the pulse by it. Mixed-polarity runs, with out-of-window excursions placed inside them, expose a run counter that fails to restart or that resets on noise. The pass sequence checks locking, delimiter flips, ignored delimiters in link fail, and re-arming, each of which a wrong design would show as a stale or wrongly flipped invert.

// File: rtl/rx_polarity_fixer.sv
module rx_polarity_fixer #(
  parameter int MIN_CYC  = 6,
  parameter int MAX_CYC  = 20,
  parameter int TAIL_CYC = 4,
  parameter int RUN_LEN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_lvl,
  input  logic neg_lvl,
  input  logic link_up,
  input  logic etd_valid,
  input  logic etd_rev,
  input  logic rx_raw,
  output logic rx_fixed,
  output logic invert,
  output logic lp_valid,
  output logic run_done
);
  localparam int WW = $clog2(MAX_CYC + 2);
  localparam int TW = $clog2(TAIL_CYC + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  typedef enum logic [1:0] {IDLE, MEAS, TAIL} st_t;

  st_t            st;
  logic [WW-1:0]  wcnt;
  logic [TW-1:0]  tcnt;
  logic           mneg;
  logic [RW-1:0]  run_cnt;
  logic           run_neg;
  logic           link_q;

  wire lvl_now    = mneg ? neg_lvl : pos_lvl;
  wire ends       = (st == MEAS) && !lvl_now;
  wire wide_ok    = (wcnt >= WW'(MIN_CYC)) && (wcnt <= WW'(MAX_CYC));
  wire qual       = ends && wide_ok;
  wire enter_pass = link_up && !link_q;
  wire enter_fail = !link_up && link_q;

  assign run_done = (run_cnt >= RW'(RUN_LEN));
  assign rx_fixed = rx_raw ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      wcnt <= '0;
      tcnt <= '0;
      mneg <= 1'b0;
    end else begin
      case (st)
        IDLE: if (pos_lvl || neg_lvl) begin
          st   <= MEAS;
          mneg <= !pos_lvl;
          wcnt <= WW'(1);
        end
        MEAS: if (lvl_now) begin
          if (wcnt != WW'(MAX_CYC + 1)) wcnt <= wcnt + 1'b1;
        end else begin
          st   <= TAIL;
          tcnt <= TW'(TAIL_CYC);
        end
        default: if (pos_lvl || neg_lvl) tcnt <= TW'(TAIL_CYC);
                 else if (tcnt == '0) st <= IDLE;
                 else tcnt <= tcnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_neg  <= 1'b0;
      link_q   <= 1'b0;
      invert   <= 1'b0;
      lp_valid <= 1'b0;
    end else begin
      link_q   <= link_up;
      lp_valid <= qual && (!link_up || (mneg == invert));
      if (enter_fail) run_cnt <= '0;
      else if (!link_up && qual) begin
        run_neg <= mneg;
        if (run_cnt == '0 || run_neg == mneg) begin
          if (run_cnt != RW'(RUN_LEN)) run_cnt <= run_cnt + 1'b1;
        end else run_cnt <= RW'(1);
      end
      if (enter_pass && run_done) invert <= run_neg;
      else if (link_up && link_q && etd_valid && etd_rev) invert <= !invert;
    end
  end

  assert_width_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lp_valid |-> ($past(wcnt) >= WW'(MIN_CYC) && $past(wcnt) <= WW'(MAX_CYC)));

  assert_invert_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(invert) |-> $past(link_up && (!link_q || etd_valid)));

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RW'(RUN_LEN));

  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |=> (run_cnt == '0));

  assert_pass_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_valid && $past(link_up)) |-> ($past(mneg) == $past(invert)));
endmodule

// File: tb/rx_polarity_fixer_test.sv
module rx_polarity_fixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MINC = 6, MAXC = 20, TAILC = 4, RUNL = 5;

  logic clk = 0, rst_n = 0;
  logic pos_lvl = 0, neg_lvl = 0, link_up = 0, etd_valid = 0, etd_rev = 0, rx_raw = 0;
  logic rx_fixed, invert, lp_valid, run_done;
  int checks = 0, failures = 0, lpn = 0;
  bit finished = 0;

  rx_polarity_fixer #(.MIN_CYC(MINC), .MAX_CYC(MAXC), .TAIL_CYC(TAILC), .RUN_LEN(RUNL)) uut (
    .clk(clk), .rst_n(rst_n), .pos_lvl(pos_lvl), .neg_lvl(neg_lvl), .link_up(link_up),
    .etd_valid(etd_valid), .etd_rev(etd_rev), .rx_raw(rx_raw), .rx_fixed(rx_fixed),
    .invert(invert), .lp_valid(lp_valid), .run_done(run_done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (lp_valid) lpn++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; link_up = 0; pos_lvl = 0; neg_lvl = 0; etd_valid = 0; etd_rev = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input bit neg, input int w1, input int w2);
    @(negedge clk);
    if (neg) neg_lvl = 1; else pos_lvl = 1;
    repeat (w1) @(negedge clk);
    pos_lvl = 0; neg_lvl = 0;
    if (w2 > 0) begin
      if (neg) pos_lvl = 1; else neg_lvl = 1;
      repeat (w2) @(negedge clk);
      pos_lvl = 0; neg_lvl = 0;
    end
    repeat (TAILC + 8) @(negedge clk);
  endtask

  task automatic set_link(input bit v);
    @(negedge clk); link_up = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic etd(input bit rev);
    @(negedge clk); etd_valid = 1; etd_rev = rev;
    @(negedge clk); etd_valid = 0; etd_rev = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b;
    do_reset();
    chk(invert == 0 && run_done == 0 && lp_valid == 0, "R11", {invert, run_done, lp_valid}, 0);

    for (int w = 1; w <= MAXC + 4; w++) begin
      int exp;
      b = lpn;
      pulse(0, w, 0);
      exp = (w >= MINC && w <= MAXC) ? 1 : 0;
      chk(lpn - b == exp, "R1", lpn - b, exp);
    end

    do_reset();
    b = lpn;
    for (int i = 0; i < RUNL; i++) pulse(0, 8, 8);
    chk(lpn - b == RUNL, "R2", lpn - b, RUNL);
    chk(run_done == 1, "R2", run_done, 1);
    set_link(1);
    chk(invert == 0, "R2", invert, 0);

    do_reset();
    for (int i = 0; i < RUNL; i++) pulse(1, 8, 8);
    set_link(1);
    chk(invert == 1, "R2", invert, 1);

    do_reset();
    for (int i = 0; i < RUNL - 1; i++) pulse(0, 10, 0);
    pulse(1, 10, 0);
    for (int i = 0; i < RUNL - 2; i++) pulse(1, 10, 0);
    chk(run_done == 0, "R4", run_done, 0);
    pulse(1, 10, 0);
    chk(run_done == 1, "R4", run_done, 1);
    set_link(1);
    chk(invert == 1, "R5", invert, 1);

    b = lpn; pulse(0, 10, 0);
    chk(lpn - b == 0, "R6", lpn - b, 0);
    b = lpn; pulse(1, 10, 0);
    chk(lpn - b == 1, "R6", lpn - b, 1);

    @(negedge clk); rx_raw = 0; #1;
    chk(rx_fixed == 1, "R8", rx_fixed, 1);
    @(negedge clk); rx_raw = 1; #1;
    chk(rx_fixed == 0, "R8", rx_fixed, 0);

    etd(1);
    chk(invert == 0, "R7", invert, 1 - 1);
    @(negedge clk); rx_raw = 1; #1;
    chk(rx_fixed == 1, "R8", rx_fixed, 1);
    etd(0);
    chk(invert == 0, "R7", invert, 0);
    etd(1);
    chk(invert == 1, "R7", invert, 1);

    set_link(0);
    chk(run_done == 0, "R9", run_done, 0);
    etd(1);
    chk(invert == 1, "R7", invert, 1);
    b = lpn; pulse(0, 10, 0);
    chk(lpn - b == 1, "R3", lpn - b, 1);
    b = lpn; pulse(1, 10, 0);
    chk(lpn - b == 1, "R3", lpn - b, 1);
    for (int i = 0; i < RUNL; i++) pulse(0, 10, 0);
    chk(run_done == 1, "R9", run_done, 1);
    set_link(1);
    chk(invert == 0, "R9", invert, 0);

    do_reset();
    for (int i = 0; i < RUNL - 1; i++) pulse(0, 10, 0);
    pulse(1, MINC - 1, 0);
    pulse(1, MAXC + 5, 0);
    chk(run_done == 0, "R10", run_done, 0);
    pulse(0, 10, 0);
    chk(run_done == 1, "R10", run_done, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule